// File: doc/BRIEF.md
# EEPROM Page-Write Sequencer

This block models the write-control logic of a byte-wide parallel EEPROM in synchronous form. A host drives address, data and three active-low strobes (chip enable, output enable, write enable) plus an active-low write-protect reset. All of these are sampled on the block clock. Each write strobe counts as a byte load into a page buffer. Loads keep arriving until the bus has been quiet for a byte-load window. The buffered page is then programmed into the storage array in an internal cycle of fixed length.

During programming the block pulls its busy line. Reads in that time return polling data instead of array contents. Every time limit is a parameter counted in clock cycles. The array is a plain register file that is cleared by the system reset. The data bus is modelled as a data output plus an output-enable flag that stands for high impedance when low. The busy line is a pull-down flag with no high state.

Top module: `eeprom_page_seq`

## Requirements
- R1: After system reset, `data_oe_o` and `busy_pull_o` are 0 and every array location reads 0.
- R2: With `ce_n_i`=0, `oe_n_i`=0, `we_n_i`=1 and `res_n_i`=1 sampled at a clock edge, and no program cycle running, `data_oe_o` is 1 after that edge and `data_o` is the array byte at `addr_i`.
- R3: After an edge that samples `ce_n_i`=1, or `oe_n_i`=1 with `we_n_i`=1, `data_oe_o` is 0.
- R4: A write strobe is `ce_n_i`=0, `we_n_i`=0 and `oe_n_i`=1. The address is taken at the first edge where the strobe is seen. The data is taken at the first edge where the strobe is gone, and a byte load happens at that edge.
- R5: If the last accepted load happens at edge E and no further load is accepted, `busy_pull_o` is 0 after edge E+WINDOW-1 and 1 after edge E+WINDOW. It then stays 1 for exactly PROG_CYC edges.
- R6: `busy_pull_o` is 1 only during a program cycle. It is a pull-down flag with no driven-high state.
- R7: While a program cycle runs, a read returns the most recently loaded byte with its top bit inverted, at any address. Once the cycle has ended, reads return the stored data.
- R8: When a program cycle ends, each loaded page offset holds its last loaded byte. The other bytes of the page, and all other pages, are unchanged.
- R9: The page is the address with its low PAGE_W bits dropped. The first load of a cycle fixes the page, and a later load to a different page is ignored.
- R10: Loads during a program cycle are ignored. They do not lengthen the busy time and do not start a new cycle.
- R11: A load that comes fewer than GAP_MIN edges after the previous accepted load is ignored.
- R12: While `res_n_i` is 0, no load is accepted and `data_oe_o` is 0. After `res_n_i` rises, loads stay ignored until RP_CYC edges have passed with it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low system reset, clears array and state |
| addr_i | input | ADDR_W | Byte address |
| data_i | input | DATA_W | Write data |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| res_n_i | input | 1 | Write-protect reset, active low |
| data_o | output | DATA_W | Read data |
| data_oe_o | output | 1 | Read data driven (0 means high impedance) |
| busy_pull_o | output | 1 | 1 pulls the busy line low |

## Verification
Some wrong internal states show up only when a page commits. A page or mask register in the wrong state writes the wrong bytes. This is seen in the array sweep after each program cycle, at least WINDOW+PROG_CYC cycles after the faulty load. A window or program counter that is off by one moves the busy edges, and the check catches this at the exact edge. A broken gap counter or protect counter lets through, or drops, a load that should not have been taken, or one that should. That shows up as a wrong byte in a later read. The checker also flags it earlier, when a load is accepted in a forbidden state or busy starts on the same cycle as a load.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_LOAD = 2'd1,
    SQ_PROG = 2'd2
  } sq_state_e;
endpackage

// File: rtl/eeprom_bus_decode.sv
module eeprom_bus_decode #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  input  logic              we_n_i,
  input  logic              res_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ld_evt_o,
  output logic [ADDR_W-1:0] ld_addr_o,
  output logic [DATA_W-1:0] ld_data_o,
  output logic              rd_req_o
);
  logic              strobe;
  logic              strobe_q;
  logic [ADDR_W-1:0] addr_q;

  // write strobe: both enables low with outputs disabled
  assign strobe = !ce_n_i && !we_n_i && oe_n_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      addr_q   <= '0;
    end else begin
      strobe_q <= strobe;
      if (strobe && !strobe_q) addr_q <= addr_i;
    end
  end

  // load happens where the strobe ends; data taken on that edge
  assign ld_evt_o  = strobe_q && !strobe;
  assign ld_addr_o = addr_q;
  assign ld_data_o = data_i;
  assign rd_req_o  = !ce_n_i && !oe_n_i && we_n_i && res_n_i;
endmodule

// File: rtl/eeprom_write_ctrl.sv
module eeprom_write_ctrl
  import eeprom_seq_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 8,
  parameter int PAGE_W   = 7,
  parameter int WINDOW   = 5000,
  parameter int GAP_MIN  = 28,
  parameter int PROG_CYC = 500000,
  parameter int RP_CYC   = 5000
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           res_n_i,
  input  logic                           ld_evt_i,
  input  logic [ADDR_W-1:0]              ld_addr_i,
  input  logic [DATA_W-1:0]              ld_data_i,
  output sq_state_e                      state_o,
  output logic                           accept_o,
  output logic                           commit_o,
  output logic [ADDR_W-PAGE_W-1:0]       page_o,
  output logic [(1<<PAGE_W)-1:0]         mask_o,
  output logic [(1<<PAGE_W)*DATA_W-1:0]  buf_o,
  output logic [DATA_W-1:0]              last_o
);
  localparam int PB    = 1 << PAGE_W;
  localparam int PG_W  = ADDR_W - PAGE_W;
  localparam int WIN_W = $clog2(WINDOW + 1);
  localparam int PRG_W = $clog2(PROG_CYC + 1);
  localparam int RP_W  = $clog2(RP_CYC + 1);

  function automatic logic [PG_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:PAGE_W];
  endfunction

  function automatic logic [PAGE_W-1:0] offset_of(input logic [ADDR_W-1:0] a);
    return a[PAGE_W-1:0];
  endfunction

  sq_state_e         state;
  logic [WIN_W-1:0]  win_cnt;
  logic [PRG_W-1:0]  prog_cnt;
  logic [RP_W-1:0]   rp_cnt;
  logic [PG_W-1:0]   page_q;
  logic [PB-1:0]     mask_q;
  logic [PB*DATA_W-1:0] buf_q;
  logic [DATA_W-1:0] last_q;

  logic write_ok, gap_ok, same_page, win_done, prog_done;
  logic [PAGE_W-1:0] ld_off;

  assign write_ok  = res_n_i && (rp_cnt == RP_W'(RP_CYC));
  assign gap_ok    = win_cnt >= WIN_W'(GAP_MIN - 1);
  assign same_page = page_of(ld_addr_i) == page_q;
  assign win_done  = win_cnt == WIN_W'(WINDOW - 1);
  assign prog_done = prog_cnt == PRG_W'(PROG_CYC - 1);
  assign ld_off    = offset_of(ld_addr_i);

  always_comb begin
    accept_o = 1'b0;
    if (ld_evt_i && write_ok) begin
      case (state)
        SQ_IDLE: accept_o = 1'b1;
        SQ_LOAD: accept_o = gap_ok && same_page;
        default: accept_o = 1'b0;
      endcase
    end
  end

  // protect timer: restarts whenever the reset pin is sampled low
  always_ff @(posedge clk) begin
    if (!rst_n)                      rp_cnt <= '0;
    else if (!res_n_i)               rp_cnt <= '0;
    else if (rp_cnt != RP_W'(RP_CYC)) rp_cnt <= rp_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      win_cnt  <= '0;
      prog_cnt <= '0;
      page_q   <= '0;
      mask_q   <= '0;
      buf_q    <= '0;
      last_q   <= '0;
    end else begin
      if (accept_o) begin
        buf_q[ld_off*DATA_W +: DATA_W] <= ld_data_i;
        last_q  <= ld_data_i;
        win_cnt <= '0;
      end
      case (state)
        SQ_IDLE: begin
          if (accept_o) begin
            state  <= SQ_LOAD;
            page_q <= page_of(ld_addr_i);
            mask_q <= PB'(1) << ld_off;
          end
        end
        SQ_LOAD: begin
          if (accept_o) begin
            mask_q <= mask_q | (PB'(1) << ld_off);
          end else if (win_done) begin
            state    <= SQ_PROG;
            prog_cnt <= '0;
          end else begin
            win_cnt <= win_cnt + 1'b1;
          end
        end
        SQ_PROG: begin
          if (prog_done) begin
            state  <= SQ_IDLE;
            mask_q <= '0;
          end else begin
            prog_cnt <= prog_cnt + 1'b1;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign state_o  = state;
  assign commit_o = (state == SQ_PROG) && prog_done;
  assign page_o   = page_q;
  assign mask_o   = mask_q;
  assign buf_o    = buf_q;
  assign last_o   = last_q;
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 7
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          commit_i,
  input  logic [ADDR_W-PAGE_W-1:0]      page_i,
  input  logic [(1<<PAGE_W)-1:0]        mask_i,
  input  logic [(1<<PAGE_W)*DATA_W-1:0] buf_i,
  input  logic [ADDR_W-1:0]             rd_addr_i,
  output logic [DATA_W-1:0]             rd_data_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PB    = 1 << PAGE_W;
  localparam int PG_W  = ADDR_W - PAGE_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // only offsets marked in the mask are rewritten on commit
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commit_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (page_i == PG_W'(i >> PAGE_W) && mask_i[i % PB])
          mem[i] <= buf_i[(i % PB)*DATA_W +: DATA_W];
      end
    end
  end

  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/eeprom_page_seq.sv
module eeprom_page_seq
  import eeprom_seq_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 8,
  parameter int PAGE_W   = 7,
  parameter int WINDOW   = 5000,
  parameter int GAP_MIN  = 28,
  parameter int PROG_CYC = 500000,
  parameter int RP_CYC   = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  input  logic              we_n_i,
  input  logic              res_n_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              busy_pull_o
);
  localparam int PB   = 1 << PAGE_W;
  localparam int PG_W = ADDR_W - PAGE_W;

  function automatic logic [DATA_W-1:0] poll_word(input logic [DATA_W-1:0] d);
    return {~d[DATA_W-1], d[DATA_W-2:0]};
  endfunction

  logic              ld_evt;
  logic [ADDR_W-1:0] ld_addr;
  logic [DATA_W-1:0] ld_data;
  logic              rd_req;
  sq_state_e         state;
  logic              load_accept;
  logic              commit;
  logic [PG_W-1:0]   page;
  logic [PB-1:0]     mask;
  logic [PB*DATA_W-1:0] pbuf;
  logic [DATA_W-1:0] last_byte;
  logic [DATA_W-1:0] arr_data;
  logic              programming;

  eeprom_bus_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n_i), .oe_n_i(oe_n_i), .we_n_i(we_n_i),
    .res_n_i(res_n_i), .addr_i(addr_i), .data_i(data_i), .ld_evt_o(ld_evt),
    .ld_addr_o(ld_addr), .ld_data_o(ld_data), .rd_req_o(rd_req)
  );

  eeprom_write_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W), .WINDOW(WINDOW),
    .GAP_MIN(GAP_MIN), .PROG_CYC(PROG_CYC), .RP_CYC(RP_CYC)
  ) u_ctl (
    .clk(clk), .rst_n(rst_n), .res_n_i(res_n_i), .ld_evt_i(ld_evt),
    .ld_addr_i(ld_addr), .ld_data_i(ld_data), .state_o(state),
    .accept_o(load_accept), .commit_o(commit), .page_o(page), .mask_o(mask),
    .buf_o(pbuf), .last_o(last_byte)
  );

  eeprom_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .commit_i(commit), .page_i(page), .mask_i(mask),
    .buf_i(pbuf), .rd_addr_i(addr_i), .rd_data_o(arr_data)
  );

  assign programming = (state == SQ_PROG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_oe_o <= 1'b0;
      data_o    <= '0;
    end else begin
      data_oe_o <= rd_req;
      data_o    <= programming ? poll_word(last_byte) : arr_data;
    end
  end

  assign busy_pull_o = programming;
endmodule

// File: rtl/eeprom_page_seq_chk.sv
module eeprom_page_seq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n_i,
  input logic              res_n_i,
  input logic [DATA_W-1:0] data_o,
  input logic              data_oe_o,
  input logic              busy_pull_o,
  input logic              load_accept,
  input logic              commit,
  input logic [DATA_W-1:0] last_byte
);
  a_r3_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ce_n_i) |-> !data_oe_o);

  a_r12_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!res_n_i) |-> !data_oe_o);

  a_r12_no_load_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !res_n_i |-> !load_accept);

  a_r10_no_load_in_prog: assert property (@(posedge clk) disable iff (!rst_n)
    busy_pull_o |-> !load_accept);

  a_r5_busy_after_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_pull_o) |-> $past(!load_accept));

  a_r8_commit_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy_pull_o);

  a_r6_busy_needs_commit_to_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_pull_o) |-> $past(commit));

  a_r7_poll_inverts: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy_pull_o) && busy_pull_o && data_oe_o) |->
      (data_o[DATA_W-1] != last_byte[DATA_W-1]));
endmodule

bind eeprom_page_seq eeprom_page_seq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n_i(ce_n_i), .res_n_i(res_n_i),
  .data_o(data_o), .data_oe_o(data_oe_o), .busy_pull_o(busy_pull_o),
  .load_accept(load_accept), .commit(commit), .last_byte(last_byte)
);

// File: tb/eeprom_page_seq_tb.sv
module eeprom_page_seq_tb;
  localparam int AW = 5, DW = 8, PW = 2;
  localparam int W = 20, GAP = 3, PROG = 40, RP = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] data_i = '0;
  logic ce_n_i = 1'b1, oe_n_i = 1'b1, we_n_i = 1'b1, res_n_i = 1'b1;
  logic [DW-1:0] data_o;
  logic data_oe_o, busy_pull_o;

  int checks = 0;
  int fails = 0;
  logic [DW-1:0] model [DEPTH];

  always #5 clk = ~clk;

  eeprom_page_seq #(
    .ADDR_W(AW), .DATA_W(DW), .PAGE_W(PW), .WINDOW(W),
    .GAP_MIN(GAP), .PROG_CYC(PROG), .RP_CYC(RP)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .data_i(data_i),
    .ce_n_i(ce_n_i), .oe_n_i(oe_n_i), .we_n_i(we_n_i), .res_n_i(res_n_i),
    .data_o(data_o), .data_oe_o(data_oe_o), .busy_pull_o(busy_pull_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] poll_of(input logic [DW-1:0] d);
    return d ^ 8'h80;
  endfunction

  function automatic logic [DW-1:0] pat(input int p, input int o);
    return DW'((p * 37 + o * 11 + 5) % 256);
  endfunction

  // normal write: address held at start, data valid at end (R4)
  task automatic write_byte(input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr_i = a; data_i = ~d; ce_n_i = 0; oe_n_i = 1; we_n_i = 0;
    @(negedge clk);
    addr_i = a ^ 5'h1F; data_i = d;
    @(negedge clk);
    ce_n_i = 1; we_n_i = 1;
    @(negedge clk);
  endtask

  task automatic fast_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr_i = a; data_i = d; ce_n_i = 0; oe_n_i = 1; we_n_i = 0;
    @(negedge clk);
    ce_n_i = 1; we_n_i = 1;
    @(negedge clk);
  endtask

  task automatic read_byte(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic oe);
    addr_i = a; ce_n_i = 0; oe_n_i = 0; we_n_i = 1;
    @(negedge clk);
    d = data_o; oe = data_oe_o;
    ce_n_i = 1; oe_n_i = 1;
  endtask

  task automatic wait_idle();
    repeat (W + 2) @(negedge clk);
    while (busy_pull_o) @(negedge clk);
  endtask

  task automatic sweep_reads(input string req);
    logic [DW-1:0] d;
    logic oe;
    for (int a = 0; a < DEPTH; a++) begin
      read_byte(AW'(a), d, oe);
      check(req, {oe, d}, {1'b1, model[a]});
    end
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    logic oe;
    int cnt;
    for (int a = 0; a < DEPTH; a++) model[a] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 oe", data_oe_o, 0);
    check("R1 busy", busy_pull_o, 0);
    repeat (RP + 2) @(negedge clk);
    sweep_reads("R1 R2 zero array");

    // R3 standby and deselect
    ce_n_i = 1; oe_n_i = 0; we_n_i = 1;
    @(negedge clk);
    check("R3 standby", data_oe_o, 0);
    ce_n_i = 0; oe_n_i = 1; we_n_i = 1;
    @(negedge clk);
    check("R3 deselect", data_oe_o, 0);
    ce_n_i = 1;
    @(negedge clk);

    // page sweep: partial and full masks, exact busy timing (R4 R5 R8)
    for (int p = 0; p < (1 << (AW - PW)); p++) begin
      int m = (p * 5 + 3) & 15;
      int ho = 0;
      for (int o = 0; o < 4; o++) if (m[o]) ho = o;
      for (int o = 0; o < 4; o++) begin
        if (m[o]) begin
          write_byte(AW'(p * 4 + o), pat(p, o));
          if (o == ho) begin
            repeat (W - 1) @(posedge clk);
            #1 check("R5 not yet busy", busy_pull_o, 0);
            @(posedge clk);
            #1 check("R5 busy start", busy_pull_o, 1);
            repeat (PROG - 1) @(posedge clk);
            #1 check("R5 R6 busy hold", busy_pull_o, 1);
            @(posedge clk);
            #1 check("R5 R6 busy end", busy_pull_o, 0);
            @(negedge clk);
          end
        end
      end
      for (int o = 0; o < 4; o++) if (m[o]) model[p * 4 + o] = pat(p, o);
      sweep_reads("R8 R4 page commit");
    end

    // R7 polling during program
    write_byte(5'h09, 8'h5A);
    repeat (W + 2) @(negedge clk);
    read_byte(5'h00, d, oe);
    check("R7 poll a", {oe, d}, {1'b1, poll_of(8'h5A)});
    read_byte(5'h1F, d, oe);
    check("R7 poll b", {oe, d}, {1'b1, poll_of(8'h5A)});
    wait_idle();
    model[9] = 8'h5A;
    read_byte(5'h09, d, oe);
    check("R7 true data after", {oe, d}, {1'b1, 8'h5A});
    @(negedge clk);

    // R10 load during program ignored, busy length unchanged
    write_byte(5'h0C, 8'hC3);
    while (!busy_pull_o) @(negedge clk);
    cnt = 1;
    write_byte(5'h0D, 8'h11);
    cnt += 3;
    forever begin
      @(negedge clk);
      if (busy_pull_o) cnt++;
      else break;
    end
    check("R10 busy length", cnt, PROG);
    model[12] = 8'hC3;
    repeat (W + 5) @(negedge clk);
    check("R10 no new cycle", busy_pull_o, 0);
    read_byte(5'h0D, d, oe);
    check("R10 ignored byte", d, model[13]);
    @(negedge clk);

    // R9 page lock
    write_byte(5'h0E, 8'h77);
    write_byte(5'h11, 8'h99);
    wait_idle();
    model[14] = 8'h77;
    read_byte(5'h0E, d, oe);
    check("R9 first page kept", d, 8'h77);
    read_byte(5'h11, d, oe);
    check("R9 other page ignored", d, model[17]);
    @(negedge clk);

    // R11 minimum gap
    write_byte(5'h14, 8'h21);
    fast_write(5'h15, 8'h42);
    wait_idle();
    model[20] = 8'h21;
    read_byte(5'h14, d, oe);
    check("R11 spaced load", d, 8'h21);
    read_byte(5'h15, d, oe);
    check("R11 close load ignored", d, model[21]);
    @(negedge clk);

    // R12 write protect
    res_n_i = 0;
    read_byte(5'h14, d, oe);
    check("R12 outputs off", oe, 0);
    write_byte(5'h18, 8'h66);
    res_n_i = 1;
    write_byte(5'h19, 8'h67);
    repeat (W + 5) @(negedge clk);
    check("R12 no cycle", busy_pull_o, 0);
    read_byte(5'h18, d, oe);
    check("R12 low blocked", d, model[24]);
    read_byte(5'h19, d, oe);
    check("R12 protect time", d, model[25]);
    @(negedge clk);
    write_byte(5'h18, 8'h66);
    wait_idle();
    read_byte(5'h18, d, oe);
    check("R12 accepted later", d, 8'h66);
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule